// File: doc/BRIEF.md
# Parallel DAC Code Register with Readback

This block is the digital front end of a current-output converter that is loaded over a 12-bit bidirectional parallel bus. An external controller drives an active-low chip select and a read/write select. A write moves the bus word through an input latch into the code register that feeds the converter core. A read puts the code register back onto the bus through a tristate driver, which is modelled as a data output plus an output enable.

The bus pins are asynchronous to the fast system clock. Chip select and read/write each pass through a synchronizer chain, and the design acts on edges of the synchronized chip select. The code register never follows the bus while chip select is low. It changes only when chip select rises at the end of a write strobe, and a one-cycle pulse marks each such update. The cycle type is fixed when chip select falls. The bus word must stay stable until the synchronized chip select has risen, which is SYNC clocks after the pin rises.

Top module: `pdac_bus_if`

## Requirements
- R1: After reset the code output is 0 (zero scale), the output enable is low and the update pulse is low. A read after reset returns 0.
- R2: A write cycle (read/write low when chip select falls) loads the bus word into the code output. This happens SYNC+1 clocks after the chip select pin rises. Bit 11 is the MSB and bit 0 is the LSB.
- R3: The code output does not change while the synchronized chip select is low. This holds even when the bus word changes during the low phase.
- R4: In a read cycle (read/write high when chip select falls), the output enable goes high and the data output equals the code output. A read does not change the code output and gives no update pulse.
- R5: The output enable is low whenever the synchronized chip select is high. After the chip select pin rises, the output enable is low by the SYNC-th rising clock edge.
- R6: The cycle type is taken when chip select falls. If read/write goes high during a write, the write still completes. If read/write goes low during a read, the code output is not changed.
- R7: The update pulse is high for exactly one clock for each code register load. The code output never changes in a cycle without that pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select pin, active low, asynchronous |
| rw | input | 1 | Read/write select pin: 1 selects read, 0 selects write |
| d_in | input | 12 | Data bus input |
| d_out | output | 12 | Data bus output (readback) |
| d_oe | output | 1 | Data bus output enable |
| code | output | 12 | Code driving the converter core |
| upd | output | 1 | One-cycle pulse on each code register load |

## Verification
The assertions check three rules on every cycle: the code is frozen while the synchronized select is low, the bus driver is off while the select is high, and the driven word always matches the code. They also check that every code change comes with a single-cycle update pulse. Other behaviour can only be shown by the bench's scenarios. These are that a full strobe loads the right word, that the cycle type is kept when read/write flips mid-cycle, the exact latency from pin edge to output, and the return to zero scale on reset.

// File: rtl/pdac_bus_if.sv
module pdac_bus_if #(
  parameter int W    = 12,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         rw,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out,
  output logic         d_oe,
  output logic [W-1:0] code,
  output logic         upd
);

  logic [SYNC-1:0] cs_pipe, rw_pipe;
  logic            cs_q, rd_mode;
  logic [W-1:0]    in_latch, code_r;

  wire cs_s    = cs_pipe[SYNC-1];
  wire rw_s    = rw_pipe[SYNC-1];
  wire cs_fall = cs_q & ~cs_s;
  wire cs_rise = ~cs_q & cs_s;
  wire cyc_rd  = cs_fall ? rw_s : rd_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_pipe  <= '1;
      rw_pipe  <= '1;
      cs_q     <= 1'b1;
      rd_mode  <= 1'b0;
      in_latch <= '0;
      code_r   <= '0;
      upd      <= 1'b0;
    end else begin
      cs_pipe <= {cs_pipe[SYNC-2:0], cs_n};
      rw_pipe <= {rw_pipe[SYNC-2:0], rw};
      cs_q    <= cs_s;
      upd     <= 1'b0;
      if (cs_fall) rd_mode <= rw_s;
      if (cs_fall && rw_s) in_latch <= code_r;
      else if (!cs_s && !cyc_rd) in_latch <= d_in;
      if (cs_rise && !rd_mode) begin
        code_r <= in_latch;
        upd    <= 1'b1;
      end
    end
  end

  assign code  = code_r;
  assign d_out = in_latch;
  assign d_oe  = ~cs_s & rd_mode & rw_s;

endmodule

// File: rtl/pdac_bus_if_chk.sv
module pdac_bus_if_chk #(parameter int W = 12) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs_s,
  input logic         d_oe,
  input logic [W-1:0] d_out,
  input logic [W-1:0] code,
  input logic         upd
);
  assert_code_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> $stable(code));
  assert_oe_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |-> !d_oe);
  assert_readback_R4: assert property (@(posedge clk) disable iff (!rst_n)
    d_oe |-> (d_out == code));
  assert_upd_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> !upd);
  assert_change_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code) |-> upd);
endmodule

bind pdac_bus_if pdac_bus_if_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .d_oe(d_oe),
  .d_out(d_out), .code(code), .upd(upd)
);

// File: tb/pdac_bus_if_tb_top.sv
module pdac_bus_if_tb_top;
  localparam int W = 12;
  logic clk = 0, rst_n = 0, cs_n = 1, rw = 1;
  logic [W-1:0] d_in = '0;
  logic [W-1:0] d_out, code;
  logic d_oe, upd;
  int checks = 0, fails = 0, upd_cnt = 0;
  logic [W-1:0] exp_code = '0;
  bit done = 0;

  pdac_bus_if #(.W(W), .SYNC(2)) dut_i (.*);

  always #5 clk = ~clk;
  always @(negedge clk) if (rst_n && upd) upd_cnt++;

  function automatic logic [W-1:0] after_write(logic [W-1:0] v); return v; endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nc(int n); repeat (n) @(negedge clk); endtask

  task automatic do_write(logic [W-1:0] v, bit flip);
    int c0;
    rw = 0; d_in = v; nc(1);
    c0 = upd_cnt; cs_n = 0; nc(4);
    chk("R3 code held while low", code, exp_code);
    d_in = ~v; nc(1);
    chk("R3 code held on bus change", code, exp_code);
    d_in = v;
    if (flip) begin rw = 1; nc(3); chk("R6 no drive after flip", d_oe, 0); end
    nc(1); cs_n = 1; nc(2);
    chk("R3 code still old at SYNC", code, exp_code);
    nc(1);
    exp_code = after_write(v);
    chk(flip ? "R6 write completes" : "R2 write latency", code, exp_code);
    nc(2);
    chk("R7 one pulse per write", upd_cnt - c0, 1);
    d_in = W'($urandom);
  endtask

  task automatic do_read(bit flip);
    int c0;
    rw = 1; nc(1);
    c0 = upd_cnt; cs_n = 0; nc(4);
    chk("R4 oe in read", d_oe, 1);
    chk("R4 readback", d_out, exp_code);
    if (flip) begin rw = 0; d_in = ~exp_code; nc(4); end
    cs_n = 1; nc(1);
    if (!flip) chk("R5 oe before sync", d_oe, 1);
    nc(1);
    chk("R5 oe released", d_oe, 0);
    nc(3);
    chk(flip ? "R6 read not turned to write" : "R4 read keeps code", code, exp_code);
    chk("R4 no pulse on read", upd_cnt - c0, 0);
    rw = 1;
  endtask

  initial begin
    void'($urandom(32'd1234));
    nc(3);
    chk("R1 reset code", code, 0);
    chk("R1 reset oe", d_oe, 0);
    chk("R1 reset upd", upd, 0);
    rst_n = 1; nc(2);
    do_read(0);
    do_write(12'h800, 0); do_read(0);
    do_write(12'h001, 0); do_read(0);
    do_write(12'hFFF, 0);
    do_write(12'hFFF, 0);
    do_write(12'h5A3, 1); do_read(0);
    do_read(1); do_read(0);
    for (int i = 0; i < 40; i++) begin
      int k = $urandom_range(0, 3);
      if (k == 0) do_read($urandom_range(0, 1));
      else do_write(W'($urandom), k == 1);
    end
    rst_n = 0; exp_code = '0; nc(2);
    chk("R1 mid-run reset code", code, 0);
    rst_n = 1; nc(2);
    do_read(0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule